// File: doc/BRIEF.md
# Robbed-Bit Aware µ-law Expander

This receive-path block turns 8-bit µ-law bytes taken off a PCM highway into signed linear samples. It also decides, frame by frame, whether the current frame carries robbed-bit signaling. It decides this by measuring how long the frame sync pulse stays high. The pulse is sampled on the falling edge of the PCM clock. A frame is treated as robbed when its pulse covers exactly two samples and the pulse before it did not. Two further conditions must hold: robbed-bit handling is enabled, and the µ-law companding mode is selected.

In a robbed frame the received least significant bit carries signaling, not voice. The expander therefore discards that bit and puts a value of half its weight in its place. The worst-case reconstruction error drops from one step to half a step. To hold that half step, the output carries one fractional bit: every sample is the linear value times two.

Each strobed byte produces a registered result one clock later. The result comes with a valid flag and a flag that marks samples expanded with the substitution. The transmit direction is not touched.

Top module: `rb_ulaw_expander`

## Requirements
- R1: Frame sync is sampled only on the falling edge of `clk`. A high level that starts and ends between two falling edges is not seen as a pulse and does not change the classification.
- R2: When `fsync` falls, the frame is classified as robbed if four things hold: `rob_en` is 1, `law_sel` is 0 (µ-law), the pulse just ended covered exactly 2 falling-edge samples, and the pulse before it did not cover exactly 2.
- R3: The "previous pulse was two samples" flag is updated at the end of every pulse, whether or not that frame qualified. So the second of two consecutive two-sample pulses is not a robbed frame.
- R4: A pulse of 1 or of 3 samples never produces a robbed frame.
- R5: With `rob_en` at 0, no sample is expanded with substitution and `out_rob` stays 0.
- R6: With `law_sel` at 1 (A-law), substitution is off and `out_rob` stays 0. This also applies inside a frame that was already classified as robbed, and it takes effect on the next strobe.
- R7: Normal expansion works as follows. Let i = ~`pcm_byte`. Then sign = i[7], segment s = i[6:4] and mantissa m = i[3:0]. The output is ±2·(((2m+33)<<s)−33), negative when the sign is 1. A negative zero gives 0.
- R8: In a robbed frame, `pcm_byte[0]` is ignored. With m' = m with bit 0 cleared, the magnitude in half units is ((4m'+68)<<s)−66. This is always nonzero.
- R9: A byte strobed with `pcm_vld` gives `out_vld`=1 and its sample on `out_sample` after exactly one rising edge. `out_rob` is 1 only together with `out_vld`.
- R10: In a cycle with no strobe, `out_vld` is 0 on the next edge and `out_sample` keeps its last value.
- R11: After reset, `out_vld`, `out_rob` and `out_sample` are 0. The previous-pulse flag is cleared, so the first two-sample pulse after reset qualifies.
- R12: A classification holds for every strobed byte until the next pulse of frame sync ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM clock; frame sync is captured on its falling edge, all else on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync pulse |
| rob_en | input | 1 | Enables robbed-bit handling |
| law_sel | input | 1 | Companding mode: 0 µ-law, 1 A-law |
| pcm_byte | input | 8 | Received companded byte |
| pcm_vld | input | 1 | Strobe marking `pcm_byte` as a valid time slot |
| out_vld | output | 1 | Result valid, one clock after the strobe |
| out_rob | output | 1 | Result was expanded with half-step substitution |
| out_sample | output | 16 | Signed linear sample in half units |

## Verification
A wrong pulse-width count or a stale previous-pulse flag stays hidden until a byte is strobed after the next falling edge of frame sync. At that point the error shows on the very next rising edge: `out_rob` is wrong, and so is `out_sample`, by exactly half a segment step. The bench therefore follows every frame-sync pattern with a strobed byte whose two possible results differ. The patterns are back-to-back two-sample pulses, a rising-edge-only glitch, and wider and narrower pulses. A fault in the mantissa substitution or the segment shift shows on the first strobed byte as a sample value that departs from the closed formula.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

    localparam int BYTE_W   = 8;
    localparam int SEG_W    = 3;
    localparam int MAN_W    = 4;
    localparam int MAG_W    = 15;
    localparam int OUT_W    = MAG_W + 1;
    localparam int FS_CNT_W = 3;
    localparam int RB_WIDTH = 2;
    localparam int BIAS_HALF = 66;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    typedef struct packed {
        logic                    sign;
        logic [SEG_W-1:0]        seg;
        logic [MAN_W-1:0]        man;
    } ulaw_fields_t;

    typedef struct packed {
        logic                    vld;
        logic                    rob;
        logic signed [OUT_W-1:0] sample;
    } rbx_out_t;

    // Received bytes are transmitted inverted; undo that and split the fields.
    function automatic ulaw_fields_t split_ulaw(input logic [BYTE_W-1:0] b);
        return ulaw_fields_t'(~b);
    endfunction

    // Expansion in half units; rob replaces the mantissa LSB with one half.
    function automatic logic signed [OUT_W-1:0] expand_half(input ulaw_fields_t f,
                                                            input logic rob);
        logic [MAN_W:0]   mq;
        logic [MAG_W-1:0] base;
        logic [MAG_W-1:0] mag;
        mq   = rob ? {f.man[MAN_W-1:1], 2'b01} : {f.man, 1'b0};
        base = MAG_W'({mq, 1'b0}) + MAG_W'(BIAS_HALF);
        mag  = (base << f.seg) - MAG_W'(BIAS_HALF);
        return f.sign ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    endfunction

endpackage

// File: rtl/rbx_fs_classifier.sv
module rbx_fs_classifier
    import rbx_pkg::*;
#(
    parameter int CNT_W   = FS_CNT_W,
    parameter int TARGET  = RB_WIDTH
) (
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    input  logic rob_en,
    input  law_e law,
    output logic rob_frame
);

    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] CNT_TARGET = CNT_W'(TARGET);

    logic             fs_s;
    logic             fs_q;
    logic [CNT_W-1:0] width_cnt;
    logic             prev_two;
    logic             pulse_end;
    logic             is_two;

    // Frame sync capture point: falling edge of the PCM clock.
    always_ff @(negedge clk) begin
        if (rst) fs_s <= 1'b0;
        else     fs_s <= fsync;
    end

    assign pulse_end = fs_q && !fs_s;
    assign is_two    = (width_cnt == CNT_TARGET);

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q      <= 1'b0;
            width_cnt <= '0;
            prev_two  <= 1'b0;
            rob_frame <= 1'b0;
        end else begin
            fs_q <= fs_s;
            if (pulse_end) begin
                rob_frame <= rob_en && (law == LAW_MU) && is_two && !prev_two;
                prev_two  <= is_two;
                width_cnt <= '0;
            end else if (fs_s && width_cnt != CNT_MAX) begin
                width_cnt <= width_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rbx_expand_core.sv
module rbx_expand_core
    import rbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] pcm_byte,
    input  logic              pcm_vld,
    input  logic              rob_active,
    output rbx_out_t          res_q
);

    ulaw_fields_t            fields;
    logic signed [OUT_W-1:0] lin_half;

    always_comb begin
        fields   = split_ulaw(pcm_byte);
        lin_half = expand_half(fields, rob_active);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= pcm_vld;
            res_q.rob <= pcm_vld && rob_active;
            if (pcm_vld) res_q.sample <= lin_half;
        end
    end

endmodule

// File: rtl/rb_ulaw_expander.sv
module rb_ulaw_expander
    import rbx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fsync,
    input  logic                    rob_en,
    input  logic                    law_sel,
    input  logic [BYTE_W-1:0]       pcm_byte,
    input  logic                    pcm_vld,
    output logic                    out_vld,
    output logic                    out_rob,
    output logic signed [OUT_W-1:0] out_sample
);

    law_e     law;
    logic     rob_frame;
    logic     rob_active;
    rbx_out_t res_q;

    assign law = law_e'(law_sel);

    rbx_fs_classifier #(
        .CNT_W  (FS_CNT_W),
        .TARGET (RB_WIDTH)
    ) u_cls (
        .clk       (clk),
        .rst       (rst),
        .fsync     (fsync),
        .rob_en    (rob_en),
        .law       (law),
        .rob_frame (rob_frame)
    );

    // Mode bits also gate the latched classification so a change applies at once.
    assign rob_active = rob_frame && rob_en && (law == LAW_MU);

    rbx_expand_core u_core (
        .clk        (clk),
        .rst        (rst),
        .pcm_byte   (pcm_byte),
        .pcm_vld    (pcm_vld),
        .rob_active (rob_active),
        .res_q      (res_q)
    );

    assign out_vld    = res_q.vld;
    assign out_rob    = res_q.rob;
    assign out_sample = res_q.sample;

endmodule

// File: rtl/rbx_checker.sv
module rbx_checker
    import rbx_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    rob_en,
    input logic                    law_sel,
    input logic                    pcm_vld,
    input logic                    out_vld,
    input logic                    out_rob,
    input logic signed [OUT_W-1:0] out_sample
);

    localparam int MAX_HALF = 16062;

    p_vld_latency_r9: assert property (@(posedge clk) disable iff (rst)
        pcm_vld |=> out_vld);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !pcm_vld |=> (!out_vld && $stable(out_sample)));

    p_rob_needs_vld_r9: assert property (@(posedge clk) disable iff (rst)
        out_rob |-> out_vld);

    // R5 and R6: substitution only under enable and µ-law mode
    p_rob_mode_gate_r6: assert property (@(posedge clk) disable iff (rst)
        out_rob |-> ($past(rob_en) && !$past(law_sel)));

    p_rob_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        out_rob |-> (out_sample != 0));

    p_sample_range_r7: assert property (@(posedge clk) disable iff (rst)
        (out_sample <= MAX_HALF) && (out_sample >= -MAX_HALF));

endmodule

bind rb_ulaw_expander rbx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rob_en     (rob_en),
    .law_sel    (law_sel),
    .pcm_vld    (pcm_vld),
    .out_vld    (out_vld),
    .out_rob    (out_rob),
    .out_sample (out_sample)
);

// File: tb/rb_ulaw_expander_tb.sv
module rb_ulaw_expander_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 12;

    typedef struct packed {
        logic [7:0]   b;
        logic         rob;
        logic [31:0]  exp;
    } vec_t;

    // Byte, robbed frame, expected sample in half units (R7, R8)
    localparam vec_t VECS [N_VEC] = '{
        '{8'hFF, 1'b0, 32'sd0},
        '{8'hFF, 1'b1, 32'sd2},
        '{8'h00, 1'b0, -32'sd16062},
        '{8'h00, 1'b1, -32'sd15806},
        '{8'h7F, 1'b0, 32'sd0},
        '{8'h80, 1'b0, 32'sd16062},
        '{8'hB5, 1'b0, 32'sd1630},
        '{8'hB5, 1'b1, 32'sd1662},
        '{8'h5A, 1'b0, -32'sd278},
        '{8'h5A, 1'b1, -32'sd270},
        '{8'hE3, 1'b0, 32'sd162},
        '{8'hE3, 1'b1, 32'sd166}
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               fsync;
    logic               rob_en;
    logic               law_sel;
    logic [7:0]         pcm_byte;
    logic               pcm_vld;
    logic               out_vld;
    logic               out_rob;
    logic signed [15:0] out_sample;

    int n_total = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rb_ulaw_expander u_dut (
        .clk        (clk),
        .rst        (rst),
        .fsync      (fsync),
        .rob_en     (rob_en),
        .law_sel    (law_sel),
        .pcm_byte   (pcm_byte),
        .pcm_vld    (pcm_vld),
        .out_vld    (out_vld),
        .out_rob    (out_rob),
        .out_sample (out_sample)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int w);
        @(posedge clk); #1 fsync = 1'b1;
        repeat (w) @(posedge clk);
        #1 fsync = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    // High only between a falling and the next rising edge plus a little
    task automatic glitch();
        @(negedge clk); #1 fsync = 1'b1;
        @(posedge clk); #1 fsync = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int exp_rob, input int exp_s,
                        input string tag);
        @(posedge clk); #1 pcm_byte = b; pcm_vld = 1'b1;
        @(posedge clk); #(CLK_PERIOD/2) pcm_vld = 1'b0;
        check(int'(out_vld), 1, {tag, " R9 out_vld"});
        check(int'(out_rob), exp_rob, {tag, " out_rob"});
        check(int'(out_sample), exp_s, {tag, " out_sample"});
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst = 1'b1; fsync = 1'b0; rob_en = 1'b1; law_sel = 1'b0;
        pcm_byte = 8'h00; pcm_vld = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #(CLK_PERIOD/2);
        check(int'(out_vld), 0, "R11 reset out_vld");
        check(int'(out_rob), 0, "R11 reset out_rob");
        check(int'(out_sample), 0, "R11 reset out_sample");

        // R11, R2: first two-sample pulse after reset qualifies
        pulse(2);
        send(8'hB5, 1, 1662, "R11 first pulse");
        // R3: a second consecutive two-sample pulse does not
        pulse(2);
        send(8'hB5, 0, 1630, "R3 back-to-back");
        // R1: rising-edge-only glitch is invisible, flag stays set
        glitch();
        pulse(2);
        send(8'hB5, 0, 1630, "R1 glitch ignored");
        // R4: three-sample pulse
        pulse(1);
        pulse(3);
        send(8'hB5, 0, 1630, "R4 width three");
        // R4: one-sample pulse after a two-sample one
        pulse(2);
        pulse(1);
        send(8'hB5, 0, 1630, "R4 width one");
        // R5: enable low
        rob_en = 1'b0;
        pulse(1);
        pulse(2);
        send(8'hB5, 0, 1630, "R5 disabled");
        rob_en = 1'b1;
        // R6: A-law inside a robbed frame, R12 the frame still holds afterwards
        pulse(1);
        pulse(2);
        law_sel = 1'b1;
        send(8'hB5, 0, 1630, "R6 A-law");
        law_sel = 1'b0;
        send(8'hB5, 1, 1662, "R12 hold in frame");
        send(8'h5A, 1, -270, "R12 second byte");
        // R10: idle cycle keeps the sample
        @(posedge clk); #(CLK_PERIOD/2);
        check(int'(out_vld), 0, "R10 idle out_vld");
        check(int'(out_sample), -270, "R10 idle hold");
        check(int'(out_rob), 0, "R9 rob without vld");

        // R7, R8: table walk
        for (int k = 0; k < N_VEC; k++) begin
            if (VECS[k].rob) begin
                pulse(1);
                pulse(2);
            end else begin
                pulse(1);
            end
            send(VECS[k].b, int'(VECS[k].rob), int'($signed(VECS[k].exp)),
                 VECS[k].rob ? "R8 table" : "R7 table");
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule